// File: doc/BRIEF.md
# Pixel-Aware Sprite Byte Combiner

This block merges one byte of background screen data with one byte of sprite data. Both bytes are packed, so each holds several pixels. A pixel whose bits are all zero counts as transparent. The pixel layout is not fixed in hardware. A programmable pixel mask marks the bits that belong to the leftmost pixel. Rotating that mask right across the byte finds the bits of every other pixel, so one circuit serves 1, 2 and 4 bits per pixel.

For each accepted column, the block builds a transparency mask from one of the two bytes. It then combines the bytes under a 2-bit plot mode: sprite in front, sprite behind, sprite opaque, or exclusive-OR. When the column carries no sprite byte, the screen byte goes through unchanged.

Data enters and leaves on a valid/ready stream with a single registered stage. The input side is ready whenever the output register is empty or is being drained in the same cycle. When the output is valid and `out_ready` is low, the output holds and back-pressure reaches the input at once. Plot mode, pixel mask and the sprite-present flag are sampled together with the data beat.

Top module: `sprite_byte_combiner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` is low and `out_byte` is 0x00; `in_ready` is high.
- R2: For plot mode 2'b00 (front), the output is (T(sprite) AND screen) OR sprite.
- R3: For plot mode 2'b01 (behind), the output is (T(screen) AND sprite) OR screen.
- R4: For plot mode 2'b10 (opaque), the output equals the sprite byte, whatever the background holds.
- R5: For plot mode 2'b11 (xor), the transparency mask is all ones and OR is replaced by XOR, so the output is screen XOR sprite.
- R6: T(d) is defined with R(k) as the pixel mask rotated right by k bits. T(d) is the OR of every R(k), for k from 0 to 7, for which d AND R(k) is zero. Useful pixel masks are 0x80 for 1 bit per pixel, 0x88 for 2 (pixel bits 7/3, 6/2, 5/1 and 4/0), and 0xAA for 4 (bits 7/5/3/1 form one pixel and 6/4/2/0 the other).
- R7: When `spr_present` is low, the output equals the screen byte in every plot mode.
- R8: A beat is accepted when `in_valid` and `in_ready` are both high at a rising edge; its result shows on `out_byte` with `out_valid` high from that edge on. `out_valid` falls after a transfer on the output side when no new beat is accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` stays stable.
- R10: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| scr_byte | input | 8 | Packed background screen byte |
| spr_byte | input | 8 | Packed sprite byte |
| spr_present | input | 1 | Sprite byte is valid for this column |
| pix_mask | input | 8 | Bits of the leftmost pixel |
| plot_mode | input | 2 | 00 front, 01 behind, 10 opaque, 11 xor |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_byte | output | 8 | Combined byte |

## Verification
The same screen and sprite bytes are run under pixel masks 0x80, 0x88 and 0xAA. A partly lit pixel then yields a different result in each format, which shows that transparency is judged per pixel and not per bit. Some background bytes are chosen with every pixel non-zero and some with only one non-zero pixel, so the front and behind modes each decide at least one case the other mode would decide differently. Opaque and xor vectors use an all-zero or all-one operand, which shows that they ignore the mask. Vectors with the sprite flag cleared, across several modes, check that the screen byte goes through untouched. A stalled output with a second beat waiting checks the hold and the release.

// File: rtl/sprc_pkg.sv
package sprc_pkg;
  typedef enum logic [1:0] {
    PM_FRONT  = 2'b00,
    PM_BEHIND = 2'b01,
    PM_OPAQUE = 2'b10,
    PM_XOR    = 2'b11
  } plot_mode_e;
endpackage

// File: rtl/sprc_zero_mask.sv
// Marks every bit that belongs to an all-zero pixel of data_i.
module sprc_zero_mask #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] pix_mask_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] rot  [W];
  logic [W-1:0] term [W];

  for (genvar k = 0; k < W; k++) begin : g_step
    if (k == 0) begin : g_r0
      assign rot[k] = pix_mask_i;
    end else begin : g_rk
      assign rot[k] = {pix_mask_i[k-1:0], pix_mask_i[W-1:k]};
    end
    assign term[k] = ((data_i & rot[k]) == '0) ? rot[k] : '0;
  end

  always_comb begin
    mask_o = '0;
    for (int k = 0; k < W; k++) begin
      mask_o = mask_o | term[k];
    end
  end
endmodule

// File: rtl/sprc_merge.sv
// Applies the plot mode to the two bytes and their transparency masks.
module sprc_merge
  import sprc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] scr_i,
  input  logic [W-1:0] spr_i,
  input  logic [W-1:0] t_scr_i,
  input  logic [W-1:0] t_spr_i,
  input  logic         present_i,
  input  plot_mode_e   mode_i,
  output logic [W-1:0] merged_o
);
  always_comb begin
    if (!present_i) begin
      merged_o = scr_i;
    end else begin
      unique case (mode_i)
        PM_FRONT:  merged_o = (t_spr_i & scr_i) | spr_i;
        PM_BEHIND: merged_o = (t_scr_i & spr_i) | scr_i;
        PM_OPAQUE: merged_o = spr_i;
        PM_XOR:    merged_o = scr_i ^ spr_i;
        default:   merged_o = scr_i;
      endcase
    end
  end
endmodule

// File: rtl/sprc_out_stage.sv
// Single registered valid/ready stage.
module sprc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] data_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready_o  = !vld_q || out_ready_i;
  assign out_valid_o = vld_q;
  assign data_o      = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        dat_q <= data_i;
      end
    end
  end
endmodule

// File: rtl/sprite_byte_combiner.sv
module sprite_byte_combiner
  import sprc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] scr_byte,
  input  logic [BYTE_W-1:0] spr_byte,
  input  logic              spr_present,
  input  logic [BYTE_W-1:0] pix_mask,
  input  logic [1:0]        plot_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte
);
  logic [BYTE_W-1:0] t_scr, t_spr, merged;

  sprc_zero_mask #(.W(BYTE_W)) u_mask_spr (
    .data_i(spr_byte), .pix_mask_i(pix_mask), .mask_o(t_spr)
  );

  sprc_zero_mask #(.W(BYTE_W)) u_mask_scr (
    .data_i(scr_byte), .pix_mask_i(pix_mask), .mask_o(t_scr)
  );

  sprc_merge #(.W(BYTE_W)) u_merge (
    .scr_i(scr_byte), .spr_i(spr_byte), .t_scr_i(t_scr), .t_spr_i(t_spr),
    .present_i(spr_present), .mode_i(plot_mode_e'(plot_mode)), .merged_o(merged)
  );

  sprc_out_stage #(.W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .data_i(merged), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .data_o(out_byte)
  );
endmodule

// File: rtl/sprc_checker.sv
module sprc_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] scr_byte,
  input logic [BYTE_W-1:0] spr_byte,
  input logic              spr_present,
  input logic [1:0]        plot_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_byte
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> !out_valid && out_byte == '0); // R1

  AST_OPAQUE_COPY: assert property (@(posedge clk) disable iff (rst)
    acc && spr_present && plot_mode == 2'b10 |=> out_byte == $past(spr_byte)); // R4

  AST_XOR_MIX: assert property (@(posedge clk) disable iff (rst)
    acc && spr_present && plot_mode == 2'b11 |=> out_byte == ($past(scr_byte) ^ $past(spr_byte))); // R5

  AST_NO_SPRITE_PASS: assert property (@(posedge clk) disable iff (rst)
    acc && !spr_present |=> out_byte == $past(scr_byte)); // R7

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte)); // R9

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R10
endmodule

bind sprite_byte_combiner sprc_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .scr_byte(scr_byte), .spr_byte(spr_byte), .spr_present(spr_present),
  .plot_mode(plot_mode), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte)
);

// File: tb/sprite_byte_combiner_tb_top.sv
module sprite_byte_combiner_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] scr_byte = 8'h00;
  logic [7:0] spr_byte = 8'h00;
  logic       spr_present = 1'b0;
  logic [7:0] pix_mask = 8'h80;
  logic [1:0] plot_mode = 2'b00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sprite_byte_combiner dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .scr_byte(scr_byte), .spr_byte(spr_byte), .spr_present(spr_present),
    .pix_mask(pix_mask), .plot_mode(plot_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  // {screen, sprite, pixel mask, mode, present, expected}
  localparam int NV = 14;
  localparam logic [34:0] VEC [NV] = '{
    {8'hF0, 8'h3C, 8'h80, 2'b00, 1'b1, 8'hFC},  // R2 R6 1bpp front
    {8'hFF, 8'h80, 8'h88, 2'b00, 1'b1, 8'hF7},  // R2 R6 2bpp front
    {8'hFF, 8'h02, 8'hAA, 2'b00, 1'b1, 8'h57},  // R2 R6 4bpp front
    {8'h5A, 8'h00, 8'hAA, 2'b00, 1'b1, 8'h5A},  // R2 clear sprite
    {8'h0F, 8'hF0, 8'h88, 2'b01, 1'b1, 8'h0F},  // R3 2bpp behind, all opaque
    {8'h0F, 8'hF0, 8'h80, 2'b01, 1'b1, 8'hFF},  // R3 1bpp behind
    {8'h01, 8'hFF, 8'h88, 2'b01, 1'b1, 8'hEF},  // R3 R6 one pixel hides
    {8'h40, 8'hFF, 8'hAA, 2'b01, 1'b1, 8'hEA},  // R3 R6 4bpp behind
    {8'hFF, 8'h00, 8'h88, 2'b10, 1'b1, 8'h00},  // R4 opaque zero sprite
    {8'h12, 8'hC3, 8'hAA, 2'b10, 1'b1, 8'hC3},  // R4
    {8'hA5, 8'hFF, 8'h80, 2'b11, 1'b1, 8'h5A},  // R5
    {8'h3C, 8'h0F, 8'h88, 2'b11, 1'b1, 8'h33},  // R5
    {8'h3C, 8'hFF, 8'h80, 2'b00, 1'b0, 8'h3C},  // R7 front, no sprite
    {8'h81, 8'h7E, 8'hAA, 2'b11, 1'b0, 8'h81}   // R7 xor, no sprite
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [34:0] v);
    scr_byte    = v[34:27];
    spr_byte    = v[26:19];
    pix_mask    = v[18:11];
    plot_mode   = v[10:9];
    spr_present = v[8];
    in_valid    = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", {7'd0, out_valid}, 8'h00);
    check("R1 out_byte", out_byte, 8'h00);
    check("R1 in_ready", {7'd0, in_ready}, 8'h01);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {7'd0, out_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R8 valid vec %0d", i), {7'd0, out_valid}, 8'h01);
      check($sformatf("vec %0d (R2..R7)", i), out_byte, VEC[i][7:0]);
    end

    // R8: drop after drain
    @(negedge clk);
    check("R8 valid drops", {7'd0, out_valid}, 8'h00);

    // R9/R10: stall with a second beat waiting
    out_ready = 1'b0;
    drive({8'h3C, 8'hFF, 8'h80, 2'b00, 1'b0, 8'h3C});
    @(negedge clk);
    drive({8'h00, 8'h55, 8'h80, 2'b10, 1'b1, 8'h55});
    check("R10 ready low", {7'd0, in_ready}, 8'h00);
    @(negedge clk);
    check("R9 hold byte", out_byte, 8'h3C);
    check("R9 hold valid", {7'd0, out_valid}, 8'h01);
    @(negedge clk);
    check("R9 hold byte again", out_byte, 8'h3C);
    out_ready = 1'b1;
    #0;
    check("R10 ready back", {7'd0, in_ready}, 8'h01);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second beat", out_byte, 8'h55);
    check("R8 second valid", {7'd0, out_valid}, 8'h01);
    @(negedge clk);
    check("R8 drained", {7'd0, out_valid}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule